// File: doc/BRIEF.md
# Programmable periodic interrupt generator

The block turns a slow tick enable, nominally 32.768 kHz, into a periodic interrupt. A 4-bit rate code sets the interval to a power-of-two number of ticks. At each interval boundary the block raises a periodic flag and an interrupt flag, and it drives the interrupt line from that flag. Software acknowledges by reading the status register. That read reaches the block as a one-cycle `ack_rd` pulse and clears both flags.

Configuration arrives as a write strobe with a new rate code and enable bit. The interval is recomputed only when a write actually changes one of the two. The time already spent in the current interval carries over into the new period. A policy input selects how missed interrupts are handled. With the policy off, missed interrupts are dropped. With it on, an interval that ends while the interrupt is still unacknowledged is counted. The acknowledge reads that follow then re-deliver the counted interrupts one at a time, with a bound on how many can be delivered in a row. When the period changes, the count is rescaled to the new period.

The top module resets asynchronously on `rst_n` and releases its reset synchronously, two clock edges later.

Top module: `pig_top`

## Requirements
- R1: After reset, `pf`, `irqf` and `irq` are low and the generator is idle.
- R2: The rate code is 4 bits. Codes 3 to 15 give an interval of 2^(code-1) ticks, code 1 gives 128 ticks and code 2 gives 256 ticks. The first interrupt comes on the interval's last tick after the enabling write.
- R3: When an interval ends, `pf` and `irqf` go high on the next clock edge, and `irq` always equals `irqf`. An `ack_rd` pulse clears `pf` and `irqf` unless a re-delivery (R8) sets them again.
- R4: While the rate code is 0 or the enable bit is clear, no interval ends and the missed-interrupt count is zero. Disabling the generator discards any count.
- R5: A configuration write that changes neither the rate code nor the enable bit leaves the interval phase untouched.
- R6: With the policy off, a period change keeps the ticks already elapsed, capped so that the next interrupt comes no later than the next tick. A tick in the same cycle as a changing write is not counted.
- R7: With the policy on, an interval that ends while `irqf` is set and no `ack_rd` is present adds one to the missed count. The count saturates at 2^MISS_W-1.
- R8: With the policy on, the enable bit set and a nonzero count, an `ack_rd` pulse sets `pf` and `irqf` again and decrements the count. At most 20 such re-deliveries are made. The first interval end after reaching 20 re-arms the allowance.
- R9: With the policy on, a period change sets the count to (count*old_period + elapsed) / new_period. The remainder becomes the elapsed ticks of the new interval.
- R10: With the policy off, interval ends are never counted and `ack_rd` never sets the flags again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle tick enable from the 32.768 kHz time base |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rate | input | 4 | Rate code written with `cfg_we` |
| cfg_pie | input | 1 | Periodic enable written with `cfg_we` |
| ack_rd | input | 1 | Status read pulse (acknowledge) |
| slew_en | input | 1 | 1 = count and re-deliver missed interrupts |
| pf | output | 1 | Periodic flag |
| irqf | output | 1 | Interrupt flag |
| irq | output | 1 | Interrupt line |

## Verification
The missed count has no port, so the bench can only infer it by counting the acknowledges that bring `irqf` back. The hardest state to reach is a count that is saturated while the re-delivery allowance is exhausted. The bench gets there by stopping the tick, so no new interval ends during the acknowledge runs. It first lets about forty short intervals expire unacknowledged, which saturates a deliberately narrow count. A run of acknowledges then hits the limit of 20. A single interval end re-arms the allowance, and a second run drains the rest. For the rescale, the bench builds a known count and remainder before the period change, then checks the re-delivery total and the phase of the next interrupt.

// File: rtl/pig_pkg.sv
package pig_pkg;
  // widest interval is 2^14 ticks
  localparam int CNT_W = 14;
  localparam int SH_W  = 4;

  // interval = 2^shift ticks
  function automatic logic [SH_W-1:0] rate_to_shift(input logic [3:0] code);
    case (code)
      4'd0:    return '0;
      4'd1:    return 4'd7;
      4'd2:    return 4'd8;
      default: return code - 4'd1;
    endcase
  endfunction
endpackage

// File: rtl/pig_rate_dec.sv
module pig_rate_dec
  import pig_pkg::*;
(
  input  logic [3:0]       code,
  input  logic             pie,
  output logic             active,
  output logic [SH_W-1:0]  shift,
  output logic [CNT_W-1:0] mask
);
  always_comb begin
    active = pie & (code != 4'd0);
    shift  = rate_to_shift(code);
    mask   = CNT_W'((32'd1 << shift) - 32'd1);
  end
endmodule

// File: rtl/pig_rescale.sv
module pig_rescale
  import pig_pkg::*;
#(
  parameter int MISS_W = 8
) (
  input  logic              old_active,
  input  logic              new_active,
  input  logic              slew,
  input  logic [SH_W-1:0]   old_shift,
  input  logic [SH_W-1:0]   new_shift,
  input  logic [CNT_W-1:0]  new_mask,
  input  logic [MISS_W-1:0] miss_q,
  input  logic [CNT_W-1:0]  elap_q,
  output logic [MISS_W-1:0] miss_ld,
  output logic [CNT_W-1:0]  elap_ld
);
  localparam int TOT_W = MISS_W + CNT_W;
  localparam logic [MISS_W-1:0] MISS_MAX = '1;

  logic [TOT_W-1:0] total;
  logic [TOT_W-1:0] quot;

  always_comb begin
    total   = (TOT_W'(miss_q) << old_shift) + TOT_W'(elap_q);
    quot    = total >> new_shift;
    miss_ld = miss_q;
    elap_ld = elap_q;
    if (!old_active || !new_active) begin
      miss_ld = '0;
      elap_ld = '0;
    end else if (slew) begin
      miss_ld = (quot > TOT_W'(MISS_MAX)) ? MISS_MAX : quot[MISS_W-1:0];
      elap_ld = total[CNT_W-1:0] & new_mask;
    end else if (elap_q > new_mask) begin
      elap_ld = new_mask;
    end
  end
endmodule

// File: rtl/pig_elapsed.sv
module pig_elapsed
  import pig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] mask,
  output logic [CNT_W-1:0] elap_q,
  output logic             expire
);
  logic [CNT_W-1:0] elap_d;
  logic             elap_en;

  assign expire = active & tick & ~load & (elap_q == mask);

  always_comb begin
    elap_en = load | (active & tick);
    if (load)        elap_d = load_val;
    else if (expire) elap_d = '0;
    else             elap_d = elap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       elap_q <= '0;
    else if (elap_en) elap_q <= elap_d;
  end

  // R2
  cnt_below_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (elap_q <= mask));
endmodule

// File: rtl/pig_missed.sv
module pig_missed #(
  parameter int MISS_W    = 8,
  parameter int REINJ_MAX = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MISS_W-1:0] load_val,
  input  logic              ack,
  input  logic              slew,
  input  logic              pie,
  input  logic              expire,
  input  logic              unacked,
  output logic [MISS_W-1:0] miss_q,
  output logic              reinj_go
);
  localparam int REINJ_W = $clog2(REINJ_MAX + 1);
  localparam logic [REINJ_W-1:0] LIM = REINJ_W'(REINJ_MAX);
  localparam logic [MISS_W-1:0] MISS_MAX = '1;

  logic [MISS_W-1:0]  miss_d;
  logic [REINJ_W-1:0] reinj_q, reinj_d;
  logic               count_go, miss_en, reinj_en;

  always_comb begin
    reinj_go = ack & slew & pie & ~load & (miss_q != '0) & (reinj_q < LIM);
    count_go = expire & slew & unacked & ~ack & (miss_q != MISS_MAX);
    miss_en  = load | reinj_go | count_go;
    if (load)          miss_d = load_val;
    else if (reinj_go) miss_d = miss_q - 1'b1;
    else               miss_d = miss_q + 1'b1;
    reinj_en = (expire & (reinj_q >= LIM)) | reinj_go;
    reinj_d  = (expire & (reinj_q >= LIM)) ? '0 : reinj_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_q  <= '0;
      reinj_q <= '0;
    end else begin
      if (miss_en)  miss_q  <= miss_d;
      if (reinj_en) reinj_q <= reinj_d;
    end
  end

  // R7
  miss_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_q == MISS_MAX && !load && !ack) |=> (miss_q == MISS_MAX));
  // R8
  reinj_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reinj_q <= LIM);
endmodule

// File: rtl/pig_top.sv
module pig_top
  import pig_pkg::*;
#(
  parameter int MISS_W    = 8,
  parameter int REINJ_MAX = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_we,
  input  logic [3:0] cfg_rate,
  input  logic       cfg_pie,
  input  logic       ack_rd,
  input  logic       slew_en,
  output logic       pf,
  output logic       irqf,
  output logic       irq
);
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [3:0]        rate_q;
  logic              pie_q, cfg_change;
  logic              cur_active, new_active;
  logic [SH_W-1:0]   cur_shift, new_shift;
  logic [CNT_W-1:0]  cur_mask, new_mask, elap_q, elap_ld;
  logic [MISS_W-1:0] miss_q, miss_ld;
  logic              expire, reinj_go;
  logic              pf_q, irqf_q, pf_d, irqf_d, flag_en;

  assign cfg_change = cfg_we & ((cfg_rate != rate_q) | (cfg_pie != pie_q));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rate_q <= '0;
      pie_q  <= 1'b0;
    end else if (cfg_change) begin
      rate_q <= cfg_rate;
      pie_q  <= cfg_pie;
    end
  end

  pig_rate_dec u_cur_dec (.code(rate_q), .pie(pie_q), .active(cur_active),
                          .shift(cur_shift), .mask(cur_mask));
  pig_rate_dec u_new_dec (.code(cfg_rate), .pie(cfg_pie), .active(new_active),
                          .shift(new_shift), .mask(new_mask));

  pig_rescale #(.MISS_W(MISS_W)) u_rescale (
    .old_active(cur_active), .new_active(new_active), .slew(slew_en),
    .old_shift(cur_shift), .new_shift(new_shift), .new_mask(new_mask),
    .miss_q(miss_q), .elap_q(elap_q), .miss_ld(miss_ld), .elap_ld(elap_ld));

  pig_elapsed u_elapsed (
    .clk(clk), .rst_n(rst_sync_n), .active(cur_active), .tick(tick),
    .load(cfg_change), .load_val(elap_ld), .mask(cur_mask),
    .elap_q(elap_q), .expire(expire));

  pig_missed #(.MISS_W(MISS_W), .REINJ_MAX(REINJ_MAX)) u_missed (
    .clk(clk), .rst_n(rst_sync_n), .load(cfg_change), .load_val(miss_ld),
    .ack(ack_rd), .slew(slew_en), .pie(pie_q), .expire(expire),
    .unacked(irqf_q), .miss_q(miss_q), .reinj_go(reinj_go));

  always_comb begin
    flag_en = ack_rd | expire;
    pf_d    = expire | reinj_go;
    irqf_d  = expire | reinj_go;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pf_q   <= 1'b0;
      irqf_q <= 1'b0;
    end else if (flag_en) begin
      pf_q   <= pf_d;
      irqf_q <= irqf_d;
    end
  end

  assign pf   = pf_q;
  assign irqf = irqf_q;
  assign irq  = irqf_q;

  // R4
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cur_active |-> (miss_q == '0));
  // R3
  pf_source_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(pf_q) |-> $past(expire | ack_rd));
  // R10
  no_reinject_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!slew_en && ack_rd && !expire) |=> !irqf_q);
endmodule

// File: tb/test_pig_top.sv
module test_pig_top;
  localparam int MW = 5;
  localparam int RL = 20;
  localparam int MAXM = (1 << MW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_run = 1'b0, cfg_we = 1'b0, cfg_pie = 1'b0, ack_rd = 1'b0, slew_en = 1'b0;
  logic [3:0] cfg_rate = '0;
  logic tick, pf, irqf, irq;
  int n_chk = 0, n_fail = 0;
  bit run_cmp = 0, done = 0;

  always #2 clk = ~clk;
  assign tick = tick_run & ~cfg_we;

  pig_top #(.MISS_W(MW), .REINJ_MAX(RL)) i_pig_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we), .cfg_rate(cfg_rate),
    .cfg_pie(cfg_pie), .ack_rd(ack_rd), .slew_en(slew_en),
    .pf(pf), .irqf(irqf), .irq(irq));

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0d exp %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_rate, m_pie, m_elap, m_miss, m_reinj;
  bit m_pf, m_irqf;

  function automatic int per_of(input int c);
    if (c == 0) return 0;
    if (c == 1) return 128;
    if (c == 2) return 256;
    return 1 << (c - 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    int cp, np;
    bit fire, rein, chg;
    longint tot;
    if (!rst_n) begin
      m_rate = 0; m_pie = 0; m_elap = 0; m_miss = 0; m_reinj = 0;
      m_pf = 0; m_irqf = 0;
    end else begin
      fire = 0; rein = 0;
      chg = cfg_we && (int'(cfg_rate) != m_rate || int'(cfg_pie) != m_pie);
      cp = m_pie ? per_of(m_rate) : 0;
      if (chg) begin
        np = cfg_pie ? per_of(int'(cfg_rate)) : 0;
        if (cp == 0 || np == 0) begin
          m_elap = 0; m_miss = 0;
        end else if (slew_en) begin
          tot = longint'(m_miss) * cp + m_elap;
          m_miss = (tot / np > MAXM) ? MAXM : int'(tot / np);
          m_elap = int'(tot % np);
        end else if (m_elap >= np) begin
          m_elap = np - 1;
        end
        m_rate = int'(cfg_rate); m_pie = int'(cfg_pie);
      end else if (tick && cp != 0) begin
        if (m_elap == cp - 1) begin fire = 1; m_elap = 0; end
        else m_elap++;
      end
      if (ack_rd && !chg && slew_en && m_pie != 0 && m_miss > 0 && m_reinj < RL) rein = 1;
      if (!chg) begin
        if (rein) m_miss--;
        else if (fire && slew_en && m_irqf && !ack_rd && m_miss < MAXM) m_miss++;
      end
      if (fire && m_reinj >= RL) m_reinj = 0;
      else if (rein) m_reinj++;
      if (ack_rd) begin m_pf = rein; m_irqf = rein; end
      if (fire) begin m_pf = 1; m_irqf = 1; end
    end
  end

  always @(negedge clk) begin
    if (run_cmp && !done) begin
      chk("R3 pf vs model", int'(pf), int'(m_pf));
      chk("R3 irqf vs model", int'(irqf), int'(m_irqf));
      chk("R3 irq follows irqf", int'(irq), int'(m_irqf));
    end
  end

  task automatic wcfg(input int r, input bit p);
    cfg_rate = 4'(r); cfg_pie = p; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input int n);
    tick_run = 1'b1;
    repeat (n) @(negedge clk);
    tick_run = 1'b0;
  endtask

  task automatic acks(input int n, output int re);
    re = 0;
    for (int i = 0; i < n; i++) begin
      ack_rd = 1'b1;
      @(negedge clk);
      ack_rd = 1'b0;
      if (irqf) re++;
    end
  endtask

  task automatic measure(output int n);
    n = 0;
    tick_run = 1'b1;
    do begin
      @(negedge clk);
      n++;
    end while (!irqf && n < 20000);
    tick_run = 1'b0;
  endtask

  task automatic clear();
    int d;
    wcfg(0, 0);
    acks(1, d);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired (all requirements)");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int n, c;
    int codes[5] = '{3, 5, 1, 2, 15};
    int lens[5]  = '{4, 16, 128, 256, 16384};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 pf", int'(pf), 0);
    chk("R1 irqf", int'(irqf), 0);
    chk("R1 irq", int'(irq), 0);
    run_cmp = 1;

    // policy off
    for (int k = 0; k < 5; k++) begin
      clear();
      wcfg(codes[k], 1'b1);
      measure(n);
      chk("R2 interval length", n, lens[k]);
    end
    chk("R3 irq raised", int'(irq), 1);
    acks(1, n);
    chk("R3 ack clears pf", int'(pf), 0);
    chk("R3 ack clears irqf", int'(irqf), 0);

    clear(); wcfg(0, 1'b1); run(300);
    chk("R4 code 0 idle", int'(irqf), 0);
    wcfg(3, 1'b0); run(300);
    chk("R4 enable clear idle", int'(irqf), 0);

    clear(); wcfg(4, 1'b1); run(5); wcfg(4, 1'b1); measure(n);
    chk("R5 unchanged write keeps phase", n, 3);

    clear(); wcfg(5, 1'b1); run(10); wcfg(3, 1'b1); measure(n);
    chk("R6 elapsed capped", n, 1);
    clear(); wcfg(5, 1'b1); run(2); wcfg(4, 1'b1); measure(n);
    chk("R6 elapsed carried", n, 6);

    clear(); wcfg(3, 1'b1); run(20); acks(3, c);
    chk("R10 no redelivery", c, 0);

    // policy on
    slew_en = 1'b1;
    clear(); wcfg(3, 1'b1); run(160); acks(25, c);
    chk("R8 redelivery limit", c, 20);
    run(4); acks(20, c);
    chk("R7 saturated count", c, 11);

    clear(); wcfg(4, 1'b1); run(37); wcfg(3, 1'b1); acks(10, c);
    chk("R9 rescaled count", c, 7);
    measure(n);
    chk("R9 remainder carried", n, 3);

    run(20); wcfg(3, 1'b0); wcfg(3, 1'b1); acks(3, c);
    chk("R4 disable discards count", c, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule